// File: doc/BRIEF.md
# Memory Fence Ordering Unit

This unit sits between an in-order issue stream and a memory port that may finish loads and stores in any order. Each incoming operation is a load, a store or a fence, and carries a tag. Loads and stores are sent straight to the memory request port and are tracked until their completion tag returns. A fence does not reach memory. It records how many loads and how many stores are still outstanding ahead of it. Then, according to its four-bit ordering mask, it holds back the younger kinds it constrains until those older operations have drained.

The mask bits can be combined freely, so one fence can enforce any mix of orderings. A younger operation whose kind no pending fence constrains passes at once. An operation that some fence does constrain stalls the in-order stream at the input until every older operation it must wait for has completed. Operations issued after a fence never delay that fence's release. Tags of outstanding operations are assumed to be unique.

Top module: `fence_order_unit`

## Requirements
- R1: A synchronous active-high reset empties both trackers. After reset, no request is presented while the input is idle, and a load or store is accepted at once when the memory port is ready.
- R2: With no pending fence, a load or store whose memory port is ready is accepted and presented on the request port in the same cycle, keeping its tag and its kind (req_store high for a store).
- R3: Operation codes on in_op are 2'b00 = load and 2'b01 = store; any code with bit 1 set is a fence. A fence never produces a memory request.
- R4: Mask bit 0 orders older loads before younger loads, bit 1 older stores before younger loads, bit 2 older loads before younger stores, and bit 3 older stores before younger stores. A fence with mask 0 is accepted at once and has no effect on later operations.
- R5: After a fence with bit 3 set, a younger store is refused (in_ready and req_valid low) while any store older than the fence is outstanding. It is accepted in the first cycle after the last such store completes.
- R6: After a fence with bit 0 set, a younger load is refused while any load older than the fence is outstanding. It is accepted in the first cycle after the last such load completes.
- R7: Bit 1 holds younger loads only on older stores, and bit 2 holds younger stores only on older loads. Completion of the other kind does not release them.
- R8: A younger operation whose kind is not constrained by any set mask bit of the pending fences is accepted immediately, passing the fence.
- R9: Operations accepted after a fence, whether outstanding or completed, have no effect on when that fence releases.
- R10: Every one of the 16 mask values, combined with outstanding older loads and stores, gives the blocking that the OR of its set bits implies.
- R11: With 8 loads and stores outstanding, further loads and stores are refused. One completion makes room again.
- R12: With 4 fences pending, a fence with a nonzero mask is refused. A fence whose constrained older kinds have nothing outstanding takes no tracker slot.
- R13: A load or store is never accepted while req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming operation valid |
| in_ready | output | 1 | Incoming operation accepted this cycle |
| in_op | input | 2 | Operation code: 00 load, 01 store, 1x fence |
| in_tag | input | 4 | Tag of a load or store |
| in_mask | input | 4 | Ordering mask of a fence |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory port can take a request |
| req_store | output | 1 | Request is a store (else a load) |
| req_tag | output | 4 | Request tag |
| cpl_valid | input | 1 | Completion pulse |
| cpl_tag | input | 4 | Tag of the completed operation |

## Verification
The bench builds the unit with its defaults: 8 tracked operations, 4 fence slots and 4-bit tags. These sizes are small enough to fill both trackers completely and to walk every one of the 16 masks against both younger kinds. In each sweep step one load and one store are outstanding before the fence. The bench computes from the mask bits whether the younger operation must wait on nothing, on the load, on the store or on both. It then checks the input handshake after each completion.

// File: rtl/fence_order_pkg.sv
package fence_order_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_FENCE = 2'b10
    } op_kind_e;

    // ordering bit positions in a fence mask
    localparam int ORD_LL = 0;  // older load  -> younger load
    localparam int ORD_SL = 1;  // older store -> younger load
    localparam int ORD_LS = 2;  // older load  -> younger store
    localparam int ORD_SS = 3;  // older store -> younger store

    // does a fence with this mask and these outstanding older kinds hold a younger op
    function automatic logic holds_young(input logic [3:0] mask, input logic young_store,
                                         input logic ld_busy, input logic st_busy);
        if (young_store)
            return (mask[ORD_LS] & ld_busy) | (mask[ORD_SS] & st_busy);
        return (mask[ORD_LL] & ld_busy) | (mask[ORD_SL] & st_busy);
    endfunction

    // does a fence still wait on anything older
    function automatic logic still_waiting(input logic [3:0] mask,
                                           input logic ld_busy, input logic st_busy);
        return ((mask[ORD_LL] | mask[ORD_LS]) & ld_busy) |
               ((mask[ORD_SL] | mask[ORD_SS]) & st_busy);
    endfunction

endpackage

// File: rtl/fot_op_track.sv
module fot_op_track #(
    parameter int NUM_OPS    = 8,
    parameter int NUM_FENCES = 4,
    parameter int TAG_W      = 4,
    parameter int CNT_W      = $clog2(NUM_OPS + 1),
    parameter int FSEL_W     = $clog2(NUM_FENCES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_en,
    input  logic                  alloc_store,
    input  logic [TAG_W-1:0]      alloc_tag,
    input  logic                  cpl_valid,
    input  logic [TAG_W-1:0]      cpl_tag,
    input  logic                  mark_en,
    input  logic [FSEL_W-1:0]     mark_slot,
    output logic                  full,
    output logic                  hit,
    output logic                  hit_store,
    output logic [NUM_FENCES-1:0] hit_older,
    output logic [CNT_W-1:0]      live_ld,
    output logic [CNT_W-1:0]      live_st
);
    localparam int OSEL_W = $clog2(NUM_OPS);

    logic [NUM_OPS-1:0]    ent_v;
    logic [NUM_OPS-1:0]    ent_st;
    logic [TAG_W-1:0]      ent_tag [NUM_OPS];
    logic [NUM_FENCES-1:0] ent_old [NUM_OPS];
    logic [NUM_OPS-1:0]    match;
    logic [OSEL_W-1:0]     free_idx;

    always_comb begin
        hit       = 1'b0;
        hit_store = 1'b0;
        hit_older = '0;
        live_ld   = '0;
        live_st   = '0;
        free_idx  = '0;
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            match[i] = ent_v[i] & cpl_valid & (ent_tag[i] == cpl_tag);
            if (!ent_v[i]) free_idx = OSEL_W'(i);
            if (match[i]) begin
                hit       = 1'b1;
                hit_store = ent_st[i];
                hit_older = ent_old[i];
            end else if (ent_v[i]) begin
                if (ent_st[i]) live_st = live_st + CNT_W'(1);
                else           live_ld = live_ld + CNT_W'(1);
            end
        end
        full = &ent_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_v <= '0;
        end else begin
            for (int i = 0; i < NUM_OPS; i++) begin
                if (match[i]) ent_v[i] <= 1'b0;
                if (mark_en) ent_old[i][mark_slot] <= ent_v[i] & ~match[i];
            end
            if (alloc_en) begin
                ent_v[free_idx]   <= 1'b1;
                ent_st[free_idx]  <= alloc_store;
                ent_tag[free_idx] <= alloc_tag;
                ent_old[free_idx] <= '0;
            end
        end
    end
endmodule

// File: rtl/fot_fence_track.sv
module fot_fence_track
    import fence_order_pkg::*;
#(
    parameter int NUM_FENCES = 4,
    parameter int CNT_W      = 4,
    parameter int FSEL_W     = $clog2(NUM_FENCES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push_en,
    input  logic [3:0]            push_mask,
    input  logic [CNT_W-1:0]      live_ld,
    input  logic [CNT_W-1:0]      live_st,
    input  logic                  hit,
    input  logic                  hit_store,
    input  logic [NUM_FENCES-1:0] hit_older,
    output logic                  full,
    output logic                  push_go,
    output logic [FSEL_W-1:0]     push_slot,
    output logic                  stall_load,
    output logic                  stall_store
);
    logic [NUM_FENCES-1:0] f_v;
    logic [3:0]            f_mask [NUM_FENCES];
    logic [CNT_W-1:0]      f_ld   [NUM_FENCES];
    logic [CNT_W-1:0]      f_st   [NUM_FENCES];
    logic [NUM_FENCES-1:0] f_done;

    always_comb begin
        push_slot   = '0;
        stall_load  = 1'b0;
        stall_store = 1'b0;
        for (int i = NUM_FENCES - 1; i >= 0; i--) begin
            if (!f_v[i]) push_slot = FSEL_W'(i);
            f_done[i] = f_v[i] & ~still_waiting(f_mask[i], f_ld[i] != '0, f_st[i] != '0);
            if (f_v[i]) begin
                stall_load  = stall_load  | holds_young(f_mask[i], 1'b0, f_ld[i] != '0, f_st[i] != '0);
                stall_store = stall_store | holds_young(f_mask[i], 1'b1, f_ld[i] != '0, f_st[i] != '0);
            end
        end
        full    = &f_v;
        push_go = push_en & ~full & still_waiting(push_mask, live_ld != '0, live_st != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_v <= '0;
        end else begin
            for (int i = 0; i < NUM_FENCES; i++) begin
                if (f_done[i]) begin
                    f_v[i] <= 1'b0;
                end else if (f_v[i] && hit && hit_older[i]) begin
                    if (hit_store) f_st[i] <= f_st[i] - CNT_W'(1);
                    else           f_ld[i] <= f_ld[i] - CNT_W'(1);
                end
            end
            if (push_go) begin
                f_v[push_slot]    <= 1'b1;
                f_mask[push_slot] <= push_mask;
                f_ld[push_slot]   <= live_ld;
                f_st[push_slot]   <= live_st;
            end
        end
    end
endmodule

// File: rtl/fence_order_unit.sv
module fence_order_unit
    import fence_order_pkg::*;
#(
    parameter int NUM_OPS    = 8,
    parameter int NUM_FENCES = 4,
    parameter int TAG_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_op,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [3:0]       in_mask,
    output logic             req_valid,
    input  logic             req_ready,
    output logic             req_store,
    output logic [TAG_W-1:0] req_tag,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag
);
    localparam int CNT_W  = $clog2(NUM_OPS + 1);
    localparam int FSEL_W = $clog2(NUM_FENCES);

    logic                  is_fence, is_store, op_stall, mem_go;
    logic                  op_full, fence_full, push_go;
    logic [FSEL_W-1:0]     push_slot;
    logic                  hit, hit_store, stall_load, stall_store;
    logic [NUM_FENCES-1:0] hit_older;
    logic [CNT_W-1:0]      live_ld, live_st;

    always_comb begin
        is_fence  = in_op[1];
        is_store  = (in_op == OP_STORE);
        op_stall  = is_store ? stall_store : stall_load;
        mem_go    = in_valid & ~is_fence & ~op_full & ~op_stall;
        req_valid = mem_go;
        req_store = is_store;
        req_tag   = in_tag;
        if (is_fence) in_ready = (in_mask == 4'h0) | ~fence_full;
        else          in_ready = ~op_full & ~op_stall & req_ready;
    end

    fot_op_track #(
        .NUM_OPS(NUM_OPS), .NUM_FENCES(NUM_FENCES), .TAG_W(TAG_W),
        .CNT_W(CNT_W), .FSEL_W(FSEL_W)
    ) u_ops (
        .clk(clk), .rst(rst),
        .alloc_en(mem_go & req_ready), .alloc_store(is_store), .alloc_tag(in_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .mark_en(push_go), .mark_slot(push_slot),
        .full(op_full), .hit(hit), .hit_store(hit_store), .hit_older(hit_older),
        .live_ld(live_ld), .live_st(live_st)
    );

    fot_fence_track #(
        .NUM_FENCES(NUM_FENCES), .CNT_W(CNT_W), .FSEL_W(FSEL_W)
    ) u_fences (
        .clk(clk), .rst(rst),
        .push_en(in_valid & is_fence & (in_mask != 4'h0)), .push_mask(in_mask),
        .live_ld(live_ld), .live_st(live_st),
        .hit(hit), .hit_store(hit_store), .hit_older(hit_older),
        .full(fence_full), .push_go(push_go), .push_slot(push_slot),
        .stall_load(stall_load), .stall_store(stall_store)
    );
endmodule

// File: rtl/fot_checker.sv
module fot_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_op,
    input logic [3:0]       in_mask,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_store,
    input logic             op_full,
    input logic             fence_full,
    input logic             stall_load,
    input logic             stall_store,
    input logic [CNT_W-1:0] live_ld,
    input logic [CNT_W-1:0] live_st
);
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!op_full && !fence_full && live_ld == '0 && live_st == '0));

    p_fence_no_request_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[1]) |-> !req_valid);

    p_zero_mask_free_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[1] && in_mask == 4'h0) |-> in_ready);

    p_store_held_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_store) |-> !stall_store);

    p_load_held_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store) |-> !stall_load);

    p_op_full_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op[1] && op_full) |-> (!in_ready && !req_valid));

    p_fence_full_r12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[1] && in_mask != 4'h0 && fence_full) |-> !in_ready);

    p_port_ready_r13: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_op[1] && !req_ready) |-> !in_ready);
endmodule

bind fence_order_unit fot_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_mask(in_mask), .req_valid(req_valid),
    .req_ready(req_ready), .req_store(req_store),
    .op_full(op_full), .fence_full(fence_full),
    .stall_load(stall_load), .stall_store(stall_store),
    .live_ld(live_ld), .live_st(live_st)
);

// File: tb/fence_order_unit_tb.sv
module fence_order_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_op = 2'b00;
    logic [3:0] in_tag = 4'h0;
    logic [3:0] in_mask = 4'h0;
    logic       req_valid;
    logic       req_ready = 1'b1;
    logic       req_store;
    logic [3:0] req_tag;
    logic       cpl_valid = 1'b0;
    logic [3:0] cpl_tag = 4'h0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    fence_order_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_tag(in_tag), .in_mask(in_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_tag(req_tag), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic offer(input logic [1:0] op, input logic [3:0] tag, input logic [3:0] mask,
                         output logic rdy, output logic rv);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_tag = tag; in_mask = mask;
        #1;
        rdy = in_ready;
        rv  = req_valid;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic complete(input logic [3:0] tag);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = tag;
        @(posedge clk);
        #1;
        cpl_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic rdy, rv, exp_blk;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        in_op = 2'b00; #1;
        check(req_valid == 1'b0, "R1", req_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);

        // R2: pass-through with no fence
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b01; in_tag = 4'h9; #1;
        check(req_valid && in_ready, "R2", {req_valid, in_ready}, 3);
        check(req_store == 1'b1 && req_tag == 4'h9, "R2", {req_store, req_tag}, 25);
        @(posedge clk); #1 in_valid = 1'b0;
        complete(4'h9);

        // R13: port not ready
        req_ready = 1'b0;
        offer(2'b00, 4'h5, 4'h0, rdy, rv);
        check(rdy == 1'b0, "R13", rdy, 0);
        check(rv == 1'b1, "R13", rv, 1);
        req_ready = 1'b1;

        // R4: zero-mask fence has no effect
        offer(2'b01, 4'h1, 4'h0, rdy, rv);
        offer(2'b10, 4'h0, 4'h0, rdy, rv);
        check(rdy == 1'b1 && rv == 1'b0, "R4", {rdy, rv}, 2);
        offer(2'b01, 4'h2, 4'h0, rdy, rv);
        check(rdy == 1'b1, "R4", rdy, 1);
        complete(4'h1); complete(4'h2); idle(2);

        // R5, R8, R9: store-before-store fence
        offer(2'b01, 4'h1, 4'h0, rdy, rv);
        offer(2'b10, 4'h0, 4'h8, rdy, rv);
        check(rdy == 1'b1 && rv == 1'b0, "R3", {rdy, rv}, 2);
        offer(2'b00, 4'h4, 4'h0, rdy, rv);
        check(rdy == 1'b1, "R8", rdy, 1);
        offer(2'b01, 4'h2, 4'h0, rdy, rv);
        check(rdy == 1'b0 && rv == 1'b0, "R5", {rdy, rv}, 0);
        complete(4'h1);
        offer(2'b01, 4'h2, 4'h0, rdy, rv);
        check(rdy == 1'b1, "R9", rdy, 1);
        complete(4'h4); complete(4'h2); idle(2);

        // R6: load-before-load fence
        offer(2'b00, 4'h1, 4'h0, rdy, rv);
        offer(2'b10, 4'h0, 4'h1, rdy, rv);
        offer(2'b00, 4'h2, 4'h0, rdy, rv);
        check(rdy == 1'b0, "R6", rdy, 0);
        offer(2'b01, 4'h3, 4'h0, rdy, rv);
        check(rdy == 1'b1, "R8", rdy, 1);
        complete(4'h1);
        offer(2'b00, 4'h2, 4'h0, rdy, rv);
        check(rdy == 1'b1, "R6", rdy, 1);
        complete(4'h2); complete(4'h3); idle(2);

        // R10, R7: sweep all masks against both younger kinds
        for (int m = 0; m < 16; m++) begin
            for (int y = 0; y < 2; y++) begin
                logic [3:0] mk;
                bit young_out;
                mk = 4'(m);
                young_out = 0;
                offer(2'b00, 4'h1, 4'h0, rdy, rv);
                offer(2'b01, 4'h2, 4'h0, rdy, rv);
                offer(2'b10, 4'h0, mk, rdy, rv);
                check(rdy == 1'b1, "R10", rdy, 1);
                exp_blk = (y == 1) ? (mk[2] | mk[3]) : (mk[0] | mk[1]);
                offer(2'(y), 4'h3, 4'h0, rdy, rv);
                check(rdy == !exp_blk && rv == rdy, "R10", rdy, !exp_blk);
                if (rdy) young_out = 1;
                complete(4'h1);
                if (!young_out) begin
                    exp_blk = (y == 1) ? mk[3] : mk[1];
                    offer(2'(y), 4'h3, 4'h0, rdy, rv);
                    check(rdy == !exp_blk, "R7", rdy, !exp_blk);
                    if (rdy) young_out = 1;
                end
                complete(4'h2);
                if (!young_out) begin
                    offer(2'(y), 4'h3, 4'h0, rdy, rv);
                    check(rdy == 1'b1, "R10", rdy, 1);
                end
                complete(4'h3);
                idle(2);
            end
        end

        // R11: operation tracker full
        for (int t = 0; t < 8; t++) offer(2'b00, 4'(t), 4'h0, rdy, rv);
        offer(2'b01, 4'h8, 4'h0, rdy, rv);
        check(rdy == 1'b0 && rv == 1'b0, "R11", {rdy, rv}, 0);
        complete(4'h0);
        offer(2'b01, 4'h8, 4'h0, rdy, rv);
        check(rdy == 1'b1, "R11", rdy, 1);
        for (int t = 1; t < 9; t++) complete(4'(t));
        idle(2);

        // R12: fence tracker full
        offer(2'b01, 4'h1, 4'h0, rdy, rv);
        for (int f = 0; f < 4; f++) begin
            offer(2'b10, 4'h0, 4'h8, rdy, rv);
            check(rdy == 1'b1, "R12", rdy, 1);
        end
        offer(2'b10, 4'h0, 4'h8, rdy, rv);
        check(rdy == 1'b0, "R12", rdy, 0);
        offer(2'b10, 4'h0, 4'h0, rdy, rv);
        check(rdy == 1'b1, "R4", rdy, 1);
        complete(4'h1);
        idle(2);
        for (int f = 0; f < 6; f++) begin
            offer(2'b10, 4'h0, 4'h8, rdy, rv);
            check(rdy == 1'b1, "R12", rdy, 1);
        end
        offer(2'b01, 4'h2, 4'h0, rdy, rv);
        check(rdy == 1'b1, "R12", rdy, 1);
        complete(4'h2);
        idle(2);

        finish_run();
    end
endmodule